// File: doc/BRIEF.md
# Serial Bus Slave with Coherent Time Snapshot

This block is a two-wire serial bus (I2C) slave that runs entirely on the system clock. It oversamples the SCL and SDA lines, finds START and STOP conditions, matches its 7-bit device address, and serves a 64-byte address space. The lowest eight locations belong to a neighbouring timekeeping counter. The remaining 56 locations are plain storage held inside the block.

Writes to the low eight locations leave the block as a one-cycle strobe to the counter. Reads of those locations come from a private copy of the counter's live bytes. The copy is refreshed on each START, on each STOP, and whenever the auto-incrementing pointer rolls over to zero. As a result, a multi-byte read of the time returns one consistent instant while the counter keeps running.

Two protections keep the bus safe. If SCL stays low for too long, the interface drops back to idle and waits for a new START. A power-fail input makes the slave ignore the bus completely.

Top module: `i2cs_snap_top`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal DEV_ADDR (default 7'b1101000). With any other address it drives nothing and ignores all later bytes until the next START.
- R2: In a write (direction bit 0), the first byte after the address sets the pointer from its low six bits. Every later byte is acknowledged, stored at the pointer, and then advances the pointer by one.
- R3: The pointer advances from 3Fh to 00h, in both reads and writes.
- R4: Reads of locations 00h-07h return the copy of the live time bytes taken at the most recent START, STOP or pointer roll-over to 00h. Live changes made between those events are not visible.
- R5: A read (direction bit 1) starts at the stored pointer even when no pointer write came first. The pointer advances after every byte sent. A not-acknowledge from the master releases SDA and ends the read.
- R6: A byte written to location 00h-07h appears on tw_en/tw_addr/tw_data for exactly one cycle. This happens once per byte, on the rising SCL edge of that byte's acknowledge clock.
- R7: subsec_clr pulses together with tw_en when the written location is 00h, and at no other time.
- R8: If SCL stays low for TMO_CYCLES system clocks while a transfer is in progress, SDA is released. Later bytes are ignored until a new START.
- R9: While pwr_fail is high, the slave never drives SDA, writes no location and raises no strobe.
- R10: A repeated START with no STOP in between starts a new address phase and keeps the pointer.
- R11: After reset SDA is released and no strobe is active.
- R12: The 56 storage locations 08h-3Fh keep written values from one transfer to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| pwr_fail | input | 1 | High when supply is below threshold |
| live_time | input | 64 | Live time bytes; byte k at bits [8k+7:8k] |
| tw_en | output | 1 | One-cycle write strobe to the time counter |
| tw_addr | output | 3 | Time location being written |
| tw_data | output | 8 | Byte being written |
| subsec_clr | output | 1 | Restart the counter's sub-second chain |

## Verification
In one clock cycle, the pointer advance that wraps 3Fh to 00h refreshes the time copy. In a write, the same cycle also stores the byte at 3Fh. The bench sets up both cases. In the read case, it takes a copy at a repeated START and then changes the live bytes. It then reads across 3Eh, 3Fh, 00h and 01h and expects the fresh values only after the wrap. In the write case, it writes two bytes starting at 3Fh and then checks the stored 3Fh value, the strobe for location 00h and its sub-second restart.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK_ADDR,
      ST_PTR,
      ST_ACK_PTR,
      ST_WDAT,
      ST_ACK_WDAT,
      ST_RDAT,
      ST_RACK,
      ST_SKIP
   } i2cs_state_e;

   typedef struct packed {
      logic scl_lvl;
      logic scl_rise;
      logic scl_fall;
      logic start;
      logic stop;
      logic sda;
   } bus_evt_t;

endpackage

// File: rtl/i2cs_bus_sync.sv
module i2cs_bus_sync
   import i2cs_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_i,
   input  logic     sda_i,
   input  logic     pf_i,
   output bus_evt_t evt,
   output logic     pf_s
);

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] scl_c, sda_c, pf_c;
   logic                   scl_q, sda_q;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_c[0] <= 1'b1;
               sda_c[0] <= 1'b1;
               pf_c[0]  <= 1'b0;
            end else begin
               scl_c[0] <= scl_i;
               sda_c[0] <= sda_i;
               pf_c[0]  <= pf_i;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_c[i] <= 1'b1;
               sda_c[i] <= 1'b1;
               pf_c[i]  <= 1'b0;
            end else begin
               scl_c[i] <= scl_c[i-1];
               sda_c[i] <= sda_c[i-1];
               pf_c[i]  <= pf_c[i-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_c[SYNC_STAGES-1];
         sda_q <= sda_c[SYNC_STAGES-1];
      end
   end

   logic scl_s, sda_s;
   assign scl_s = scl_c[SYNC_STAGES-1];
   assign sda_s = sda_c[SYNC_STAGES-1];

   always_comb begin
      evt.scl_lvl  = scl_s;
      evt.sda      = sda_s;
      evt.scl_rise = scl_s & ~scl_q;
      evt.scl_fall = ~scl_s & scl_q;
      evt.start    = scl_s & scl_q & sda_q & ~sda_s;
      evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
   end

   assign pf_s = pf_c[SYNC_STAGES-1];

endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
   import i2cs_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR   = 7'h68,
   parameter int         TMO_CYCLES = 1_750_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  bus_evt_t   evt,
   input  logic       pf_s,
   input  logic [7:0] rd_byte,
   output logic       sda_oe,
   output logic       ptr_load,
   output logic       wr_stb,
   output logic       rd_adv,
   output logic [7:0] rx_byte
);

   localparam int TMO_W = $clog2(TMO_CYCLES + 1);

   if (TMO_CYCLES < 16) begin : g_bad_tmo
      $error("TMO_CYCLES too small for bus timing");
   end

   i2cs_state_e      st;
   logic [7:0]       shreg, txreg;
   logic [3:0]       bcnt;
   logic             rw, nack;
   logic [TMO_W-1:0] tcnt;
   logic             tmo_hit;

   assign tmo_hit = (tcnt == TMO_W'(TMO_CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tcnt <= '0;
      else if (evt.scl_lvl || st == ST_IDLE || tmo_hit)
         tcnt <= '0;
      else
         tcnt <= tcnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         shreg    <= '0;
         txreg    <= '0;
         bcnt     <= '0;
         rw       <= 1'b0;
         nack     <= 1'b0;
         sda_oe   <= 1'b0;
         ptr_load <= 1'b0;
         wr_stb   <= 1'b0;
         rd_adv   <= 1'b0;
      end else begin
         ptr_load <= 1'b0;
         wr_stb   <= 1'b0;
         rd_adv   <= 1'b0;
         if (pf_s || tmo_hit) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
         end else if (evt.start) begin
            st     <= ST_ADDR;
            bcnt   <= '0;
            sda_oe <= 1'b0;
         end else if (evt.stop) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (st)
               ST_ADDR, ST_PTR, ST_WDAT: begin
                  if (evt.scl_rise) begin
                     shreg <= {shreg[6:0], evt.sda};
                     bcnt  <= bcnt + 1'b1;
                  end else if (evt.scl_fall && bcnt == 4'd8) begin
                     bcnt <= '0;
                     if (st == ST_ADDR) begin
                        if (shreg[7:1] == DEV_ADDR) begin
                           sda_oe <= 1'b1;
                           rw     <= shreg[0];
                           st     <= ST_ACK_ADDR;
                        end else begin
                           st <= ST_SKIP;
                        end
                     end else begin
                        sda_oe <= 1'b1;
                        st     <= (st == ST_PTR) ? ST_ACK_PTR : ST_ACK_WDAT;
                     end
                  end
               end
               ST_ACK_ADDR, ST_ACK_PTR, ST_ACK_WDAT: begin
                  if (evt.scl_rise) begin
                     ptr_load <= (st == ST_ACK_PTR);
                     wr_stb   <= (st == ST_ACK_WDAT);
                  end else if (evt.scl_fall) begin
                     if (st == ST_ACK_ADDR && rw) begin
                        txreg  <= rd_byte;
                        sda_oe <= ~rd_byte[7];
                        st     <= ST_RDAT;
                     end else begin
                        sda_oe <= 1'b0;
                        st     <= (st == ST_ACK_ADDR) ? ST_PTR : ST_WDAT;
                     end
                  end
               end
               ST_RDAT: begin
                  if (evt.scl_rise) begin
                     bcnt <= bcnt + 1'b1;
                  end else if (evt.scl_fall) begin
                     if (bcnt == 4'd8) begin
                        bcnt   <= '0;
                        sda_oe <= 1'b0;
                        st     <= ST_RACK;
                     end else begin
                        txreg  <= {txreg[6:0], 1'b0};
                        sda_oe <= ~txreg[6];
                     end
                  end
               end
               ST_RACK: begin
                  if (evt.scl_rise) begin
                     rd_adv <= 1'b1;
                     nack   <= evt.sda;
                  end else if (evt.scl_fall) begin
                     if (nack) begin
                        st <= ST_SKIP;
                     end else begin
                        txreg  <= rd_byte;
                        sda_oe <= ~rd_byte[7];
                        st     <= ST_RDAT;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign rx_byte = shreg;

   AST_PF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      pf_s |=> !sda_oe); // R9
   AST_PF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      pf_s |=> !wr_stb); // R9
   AST_TMO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_hit |=> !sda_oe); // R8
   AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb); // R6

endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile #(
   parameter int AW         = 6,
   parameter int TIME_BYTES = 8,
   localparam int TB_W      = $clog2(TIME_BYTES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [TIME_BYTES*8-1:0] live,
   input  logic                    snap_ev,
   input  logic                    ptr_load,
   input  logic [AW-1:0]           load_val,
   input  logic                    wr_stb,
   input  logic [7:0]              wr_data,
   input  logic                    rd_adv,
   output logic [7:0]              rd_byte,
   output logic                    tw_en,
   output logic [TB_W-1:0]         tw_addr,
   output logic [7:0]              tw_data,
   output logic                    subsec_clr
);

   localparam int DEPTH     = 2 ** AW;
   localparam int RAM_DEPTH = DEPTH - TIME_BYTES;
   localparam int LAST      = DEPTH - 1;

   if (TIME_BYTES != (1 << TB_W)) begin : g_bad_tb
      $error("TIME_BYTES must be a power of two");
   end
   if (RAM_DEPTH < 1) begin : g_bad_depth
      $error("Address space leaves no storage");
   end

   logic [AW-1:0]                ptr;
   logic [TIME_BYTES-1:0][7:0]   shadow;
   logic [7:0]                   ram [RAM_DEPTH];
   logic                         adv, wrap, snap, in_time;
   logic [AW-1:0]                ram_idx;

   assign adv     = wr_stb | rd_adv;
   assign wrap    = adv && (ptr == AW'(LAST));
   assign snap    = snap_ev | wrap;
   assign in_time = (ptr < AW'(TIME_BYTES));
   assign ram_idx = ptr - AW'(TIME_BYTES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr <= '0;
      else if (ptr_load)
         ptr <= load_val;
      else if (adv)
         ptr <= ptr + 1'b1;
   end

   for (genvar k = 0; k < TIME_BYTES; k++) begin : g_shadow
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            shadow[k] <= '0;
         else if (snap)
            shadow[k] <= live[k*8 +: 8];
      end
   end

   always_ff @(posedge clk) begin
      if (wr_stb && !in_time)
         ram[ram_idx] <= wr_data;
   end

   assign rd_byte    = in_time ? shadow[ptr[TB_W-1:0]] : ram[ram_idx];
   assign tw_en      = wr_stb & in_time;
   assign tw_addr    = ptr[TB_W-1:0];
   assign tw_data    = wr_data;
   assign subsec_clr = wr_stb & (ptr == '0);

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !ptr_load) |=> ptr == AW'($past(ptr) + 1'b1)); // R2
   AST_WRAP_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> shadow == $past(live)); // R3
   AST_EVT_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
      snap_ev |=> shadow == $past(live)); // R4
   AST_TW_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      tw_en |=> !tw_en); // R6
   AST_SUBSEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      subsec_clr |-> (tw_en && tw_addr == '0)); // R7

endmodule

// File: rtl/i2cs_snap_top.sv
module i2cs_snap_top
   import i2cs_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h68,
   parameter int         AW          = 6,
   parameter int         TIME_BYTES  = 8,
   parameter int         SYNC_STAGES = 2,
   parameter int         TMO_CYCLES  = 1_750_000,
   localparam int        TB_W        = $clog2(TIME_BYTES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    scl_i,
   input  logic                    sda_i,
   output logic                    sda_oe,
   input  logic                    pwr_fail,
   input  logic [TIME_BYTES*8-1:0] live_time,
   output logic                    tw_en,
   output logic [TB_W-1:0]         tw_addr,
   output logic [7:0]              tw_data,
   output logic                    subsec_clr
);

   if (AW > 8) begin : g_bad_aw
      $error("Pointer is loaded from one byte; AW must not exceed 8");
   end

   bus_evt_t   evt;
   logic       pf_s;
   logic [7:0] rd_byte, rx_byte;
   logic       ptr_load, wr_stb, rd_adv, snap_ev;

   i2cs_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_i (scl_i),
      .sda_i (sda_i),
      .pf_i  (pwr_fail),
      .evt   (evt),
      .pf_s  (pf_s)
   );

   i2cs_ctrl #(.DEV_ADDR(DEV_ADDR), .TMO_CYCLES(TMO_CYCLES)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt),
      .pf_s     (pf_s),
      .rd_byte  (rd_byte),
      .sda_oe   (sda_oe),
      .ptr_load (ptr_load),
      .wr_stb   (wr_stb),
      .rd_adv   (rd_adv),
      .rx_byte  (rx_byte)
   );

   assign snap_ev = (evt.start | evt.stop) & ~pf_s;

   i2cs_regfile #(.AW(AW), .TIME_BYTES(TIME_BYTES)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .live       (live_time),
      .snap_ev    (snap_ev),
      .ptr_load   (ptr_load),
      .load_val   (rx_byte[AW-1:0]),
      .wr_stb     (wr_stb),
      .wr_data    (rx_byte),
      .rd_adv     (rd_adv),
      .rd_byte    (rd_byte),
      .tw_en      (tw_en),
      .tw_addr    (tw_addr),
      .tw_data    (tw_data),
      .subsec_clr (subsec_clr)
   );

endmodule

// File: tb/tb_i2cs_snap_top.sv
module tb_i2cs_snap_top;

   localparam int CLK_PERIOD = 10;
   localparam int QTR        = 6;
   localparam int TMO        = 400;
   localparam int WD_LIMIT   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        m_scl = 1'b1;
   logic        m_sda = 1'b1;
   logic        pwr_fail = 1'b0;
   logic [63:0] live_time = '0;
   logic        sda_oe, tw_en, subsec_clr;
   logic [2:0]  tw_addr;
   logic [7:0]  tw_data;
   logic        sda_bus;

   int n_chk = 0, n_fail = 0, cyc = 0;
   int tw_cnt = 0, ss_cnt = 0;
   logic [2:0] tw_last_a = '0;
   logic [7:0] tw_last_d = '0;
   logic       tw_last_ss = 1'b0;
   bit         done = 1'b0;

   assign sda_bus = m_sda & ~sda_oe;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2cs_snap_top #(.TMO_CYCLES(TMO)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (m_scl),
      .sda_i      (sda_bus),
      .sda_oe     (sda_oe),
      .pwr_fail   (pwr_fail),
      .live_time  (live_time),
      .tw_en      (tw_en),
      .tw_addr    (tw_addr),
      .tw_data    (tw_data),
      .subsec_clr (subsec_clr)
   );

   always @(negedge clk) begin
      if (tw_en) begin
         tw_cnt++;
         tw_last_a  = tw_addr;
         tw_last_d  = tw_data;
         tw_last_ss = subsec_clr;
      end
      if (subsec_clr) ss_cnt++;
   end

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 37 + 11) % 256);
   endfunction

   function automatic logic [63:0] live_pat(input int n);
      logic [63:0] v;
      for (int k = 0; k < 8; k++) v[k*8 +: 8] = 8'((n * 16 + k * 3 + 1) % 256);
      return v;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic qwait();
      repeat (QTR) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; qwait();
      m_scl = 1'b1; qwait();
      m_sda = 1'b0; qwait();
      m_scl = 1'b0; qwait();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; qwait();
      m_scl = 1'b1; qwait();
      m_sda = 1'b1; qwait();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; qwait();
         m_scl = 1'b1; qwait();
         m_scl = 1'b0; qwait();
      end
      m_sda = 1'b1; qwait();
      m_scl = 1'b1; qwait();
      ack = ~sda_bus;
      m_scl = 1'b0; qwait();
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] b);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         qwait();
         m_scl = 1'b1; qwait();
         b[i] = sda_bus;
         m_scl = 1'b0;
      end
      qwait();
      m_sda = ~give_ack; qwait();
      m_scl = 1'b1; qwait();
      m_scl = 1'b0; qwait();
      m_sda = 1'b1;
   endtask

   task automatic read_one_at(input logic [7:0] p, output logic [7:0] b);
      logic a;
      bus_start();
      send_byte(8'hD0, a);
      send_byte(p, a);
      bus_start();
      send_byte(8'hD1, a);
      recv_byte(1'b0, b);
      bus_stop();
   endtask

   always @(negedge clk) begin
      cyc++;
      if (cyc > WD_LIMIT && !done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL R11 watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic       a;
      logic [7:0] b;
      int         nacks;
      int         tw0, ss0;

      repeat (3) @(negedge clk);
      chk("R11 sda released in reset", 32'(sda_oe), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R11 sda released after reset", 32'(sda_oe), 0);
      chk("R11 no strobe after reset", 32'(tw_cnt), 0);

      // R2 / R1: fill storage 08h..3Fh in one write
      live_time = live_pat(0);
      bus_start();
      send_byte(8'hD0, a);
      chk("R1 address ack", 32'(a), 1);
      send_byte(8'h08, a);
      chk("R2 pointer byte ack", 32'(a), 1);
      nacks = 0;
      for (int ad = 8; ad < 64; ad++) begin
         send_byte(pat(ad), a);
         if (!a) nacks++;
      end
      chk("R2 data bytes all acked", 32'(nacks), 0);
      bus_stop();
      chk("R2 storage writes raise no time strobe", 32'(tw_cnt), 0);

      // R12 / R10: read back with pointer write then repeated START
      bus_start();
      send_byte(8'hD0, a);
      send_byte(8'h08, a);
      bus_start();
      send_byte(8'hD1, a);
      chk("R10 read address ack after repeated start", 32'(a), 1);
      for (int ad = 8; ad < 64; ad++) begin
         recv_byte(ad != 63, b);
         chk($sformatf("R12 readback %0h", ad), 32'(b), 32'(pat(ad)));
      end
      chk("R5 sda released after nack", 32'(sda_oe), 0);
      bus_stop();

      // R4: coherent time copy
      live_time = live_pat(1);
      bus_start();
      send_byte(8'hD0, a);
      send_byte(8'h00, a);
      bus_start();
      send_byte(8'hD1, a);
      for (int k = 0; k < 8; k++) begin
         if (k == 4) live_time = live_pat(2);
         recv_byte(k != 7, b);
         chk($sformatf("R4 time byte %0d from copy", k), 32'(b),
             32'(live_pat(1)[k*8 +: 8]));
      end
      bus_stop();

      // R5: read from the stored pointer (now 08h) without a pointer write
      bus_start();
      send_byte(8'hD1, a);
      recv_byte(1'b0, b);
      bus_stop();
      chk("R5 current pointer read 08h", 32'(b), 32'(pat(8)));
      bus_start();
      send_byte(8'hD1, a);
      recv_byte(1'b0, b);
      bus_stop();
      chk("R5 pointer advanced to 09h", 32'(b), 32'(pat(9)));

      // R3 / R4: wrap during read refreshes the copy
      live_time = live_pat(3);
      bus_start();
      send_byte(8'hD0, a);
      send_byte(8'h3E, a);
      bus_start();
      send_byte(8'hD1, a);
      live_time = live_pat(4);
      recv_byte(1'b1, b);
      chk("R3 read 3Eh", 32'(b), 32'(pat(62)));
      recv_byte(1'b1, b);
      chk("R3 read 3Fh", 32'(b), 32'(pat(63)));
      recv_byte(1'b1, b);
      chk("R4 byte 00h after wrap takes fresh copy", 32'(b), 32'(live_pat(4)[7:0]));
      recv_byte(1'b0, b);
      chk("R3 byte 01h after wrap", 32'(b), 32'(live_pat(4)[15:8]));
      bus_stop();

      // R3 / R6 / R7: write across the wrap
      tw0 = tw_cnt; ss0 = ss_cnt;
      bus_start();
      send_byte(8'hD0, a);
      send_byte(8'h3F, a);
      send_byte(8'hA5, a);
      send_byte(8'h3C, a);
      bus_stop();
      chk("R6 one strobe for wrapped byte", 32'(tw_cnt - tw0), 1);
      chk("R3 strobe address after wrap", 32'(tw_last_a), 0);
      chk("R6 strobe data", 32'(tw_last_d), 32'h3C);
      chk("R7 subsec with address 00h", 32'(tw_last_ss), 1);
      chk("R7 one subsec pulse", 32'(ss_cnt - ss0), 1);
      read_one_at(8'h3F, b);
      chk("R3 3Fh written before wrap", 32'(b), 32'hA5);

      // R6 / R7: write to 05h, no subsec
      tw0 = tw_cnt; ss0 = ss_cnt;
      bus_start();
      send_byte(8'hD0, a);
      send_byte(8'h05, a);
      send_byte(8'h77, a);
      send_byte(8'h78, a);
      bus_stop();
      chk("R6 two strobes", 32'(tw_cnt - tw0), 2);
      chk("R6 last strobe address", 32'(tw_last_a), 6);
      chk("R6 last strobe data", 32'(tw_last_d), 32'h78);
      chk("R7 no subsec for 05h", 32'(ss_cnt - ss0), 0);

      // R1: address mismatch
      tw0 = tw_cnt;
      bus_start();
      send_byte(8'hD2, a);
      chk("R1 no ack for other address", 32'(a), 0);
      send_byte(8'h00, a);
      chk("R1 later byte ignored", 32'(a), 0);
      send_byte(8'h99, a);
      bus_stop();
      chk("R1 no strobe when not addressed", 32'(tw_cnt - tw0), 0);

      // R8: SCL held low during the ack
      bus_start();
      for (int i = 7; i >= 0; i--) begin
         m_sda = (8'hD0 >> i) & 1'b1; qwait();
         m_scl = 1'b1; qwait();
         m_scl = 1'b0; qwait();
      end
      m_sda = 1'b1;
      chk("R1 ack driven before timeout", 32'(sda_oe), 1);
      repeat (TMO + 40) @(negedge clk);
      chk("R8 sda released on timeout", 32'(sda_oe), 0);
      qwait();
      m_scl = 1'b1; qwait();
      m_scl = 1'b0; qwait();
      send_byte(8'h10, a);
      chk("R8 bytes ignored until START", 32'(a), 0);
      bus_stop();

      // R9: power fail blocks everything
      tw0 = tw_cnt;
      pwr_fail = 1'b1;
      repeat (10) @(negedge clk);
      bus_start();
      send_byte(8'hD0, a);
      chk("R9 no address ack in power fail", 32'(a), 0);
      send_byte(8'h10, a);
      chk("R9 no pointer ack in power fail", 32'(a), 0);
      send_byte(8'hEE, a);
      bus_stop();
      bus_start();
      send_byte(8'hD0, a);
      send_byte(8'h00, a);
      send_byte(8'h55, a);
      bus_stop();
      chk("R9 no strobe in power fail", 32'(tw_cnt - tw0), 0);
      pwr_fail = 1'b0;
      repeat (10) @(negedge clk);
      read_one_at(8'h10, b);
      chk("R9 storage unchanged by blocked write", 32'(b), 32'(pat(16)));

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule